// File: doc/BRIEF.md
# Sequential Multiply/Divide Unit

This block is the arithmetic helper that sits beside an integer datapath and performs the three long operations a single-cycle ALU does not: unsigned multiply, two's-complement multiply and unsigned divide. Each operation is available at two sizes, byte and word. The caller presents a double-width destination operand, a single-width source operand, an operation code and a size bit, and pulses a start strobe. The unit latches everything on that edge and then works one bit per clock. It raises a one-cycle completion pulse together with the packed result and, for divides, updated status flags.

Multiplication runs shift-and-add on operand magnitudes. For the signed case the product is negated at the end, so one engine serves both multiplies. Division is restoring shift-and-subtract over the whole dividend. The quotient lands in the low half of the destination field and the remainder in the high half. At byte size the upper half of the destination passes through untouched. A zero divisor is caught on the start edge: it finishes quickly and leaves the destination as it was.

Top module: `muldiv_seq`

## Requirements
- R1: While reset is asserted and after its release, busy, done, result, flag_n, flag_z and flag_dz are all 0.
- R2: Op code 0 (unsigned multiply) with wide=0 writes dst_in[7:0]*src_in[7:0] into result[15:0] and copies dst_in[31:16] into result[31:16]. With wide=1 it writes dst_in[15:0]*src_in[15:0] into result[31:0].
- R3: Op code 1 (signed multiply) treats the same operand fields as two's complement and writes the two's-complement product at the same position as R2. This includes -128*-128 and -32768*-32768.
- R4: Op code 2 (unsigned divide) with wide=0 and a non-zero src_in[7:0] divides dst_in[15:0] by it. It writes the low 8 bits of the quotient to result[7:0] and the 8-bit remainder to result[15:8], and copies dst_in[31:16] into result[31:16].
- R5: Op code 2 with wide=1 and a non-zero src_in[15:0] divides dst_in[31:0] by it. It writes the low 16 bits of the quotient to result[15:0] and the remainder to result[31:16].
- R6: An accepted start raises busy on the next cycle. Busy then stays high for exactly 8, 16, 16 or 32 cycles for byte multiply, word multiply, byte divide and word divide, and 2 cycles for a zero divisor. In the following cycle done is 1 for one cycle with busy at 0.
- R7: A divide whose divisor field is zero sets flag_dz=1 and flag_z=1 and sets flag_n to the divisor field's top bit. It returns result equal to the latched dst_in.
- R8: A divide with a non-zero divisor sets flag_n to the divisor field's top bit (src_in[7] at byte size, src_in[15] at word size) and clears flag_z and flag_dz.
- R9: Both multiplies leave flag_n, flag_z and flag_dz unchanged.
- R10: A start while busy is 1 is ignored, and a start with op code 3 is ignored: busy stays 0.
- R11: result and the flags change only in a cycle where done is 1 and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, sampled when busy is 0 |
| op | input | 2 | 0 unsigned multiply, 1 signed multiply, 2 unsigned divide, 3 reserved |
| wide | input | 1 | 0 byte size, 1 word size |
| dst_in | input | 32 | Destination operand: multiplicand or dividend |
| src_in | input | 16 | Source operand: multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse, result valid |
| result | output | 32 | Packed result, held until the next completion |
| flag_n | output | 1 | Negative flag, updated by divide |
| flag_z | output | 1 | Zero flag, updated by divide |
| flag_dz | output | 1 | Divide-by-zero status |

## Verification
The checker assumes that op, wide and both operands count only on the start edge. It also assumes that start may be pulsed at any time, including while busy or with the reserved code, so its properties cover acceptance and ignore cases without input constraints. The stimulus pulses start for one cycle and scrambles the operand inputs during the busy window, which shows that only latched values reach the result. During some runs it also fires a stray start mid-operation. The latency check relies on op codes 0 to 2 being the only accepted ones; the bench offers code 3 only as an explicit ignore case.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULU = 2'd0,
        OP_MULS = 2'd1,
        OP_DIVU = 2'd2,
        OP_RSVD = 2'd3
    } md_op_e;

endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  md_op_e                        op,
    input  logic                          wide,
    input  logic [2*W-1:0]                dst,
    input  logic [W-1:0]                  src,
    output logic [2*W-1:0]                acc_init,
    output logic [2*W-1:0]                mq_init,
    output logic [2*W-1:0]                mc_init,
    output logic [$clog2(2*W)-1:0]        cnt_init,
    output logic                          is_div,
    output logic                          neg,
    output logic                          dz,
    output logic                          dmsb
);
    localparam int HW = W / 2;
    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW);

    logic [W-1:0] lo_mask;
    logic [W-1:0] a_ext;
    logic [W-1:0] b_ext;
    logic [W-1:0] a_mag;
    logic [W-1:0] b_mag;
    logic         a_sgn;
    logic         b_sgn;
    logic         sgn_mul;

    always_comb begin
        lo_mask = wide ? {W{1'b1}} : {{(W-HW){1'b0}}, {HW{1'b1}}};
        a_ext   = dst[W-1:0] & lo_mask;
        b_ext   = src & lo_mask;
        sgn_mul = (op == OP_MULS);
        a_sgn   = sgn_mul & (wide ? dst[W-1] : dst[HW-1]);
        b_sgn   = sgn_mul & (wide ? src[W-1] : src[HW-1]);
        a_mag   = a_sgn ? ((~a_ext + W'(1)) & lo_mask) : a_ext;
        b_mag   = b_sgn ? ((~b_ext + W'(1)) & lo_mask) : b_ext;
        is_div  = (op == OP_DIVU);
        dz      = is_div & (b_ext == '0);
        dmsb    = wide ? src[W-1] : src[HW-1];
        neg     = a_sgn ^ b_sgn;
        acc_init = '0;
        if (is_div) begin
            mq_init  = wide ? dst : {dst[W-1:0], {W{1'b0}}};
            mc_init  = {{W{1'b0}}, b_ext};
            if (dz) begin
                cnt_init = CW'(1);
            end else begin
                cnt_init = wide ? CW'(DW - 1) : CW'(W - 1);
            end
        end else begin
            mq_init  = {{W{1'b0}}, b_mag};
            mc_init  = {{W{1'b0}}, a_mag};
            cnt_init = wide ? CW'(W - 1) : CW'(HW - 1);
        end
    end

endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
    parameter int W = 16
) (
    input  logic           is_div,
    input  logic [2*W-1:0] acc,
    input  logic [2*W-1:0] mq,
    input  logic [2*W-1:0] mc,
    output logic [2*W-1:0] acc_n,
    output logic [2*W-1:0] mq_n,
    output logic [2*W-1:0] mc_n
);
    localparam int DW = 2 * W;

    logic [W:0] shifted;
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        shifted = {acc[W-1:0], mq[DW-1]};
        fits    = (shifted >= {1'b0, mc[W-1:0]});
        trial   = shifted - {1'b0, mc[W-1:0]};
        if (is_div) begin
            acc_n = {{W{1'b0}}, (fits ? trial[W-1:0] : shifted[W-1:0])};
            mq_n  = {mq[DW-2:0], fits};
            mc_n  = mc;
        end else begin
            acc_n = acc + (mq[0] ? mc : '0);
            mq_n  = {1'b0, mq[DW-1:1]};
            mc_n  = {mc[DW-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/muldiv_pack.sv
module muldiv_pack #(
    parameter int W = 16
) (
    input  logic           is_div,
    input  logic           wide,
    input  logic           neg,
    input  logic           dz,
    input  logic [2*W-1:0] acc,
    input  logic [W-1:0]   quo,
    input  logic [2*W-1:0] keep,
    output logic [2*W-1:0] res
);
    localparam int HW = W / 2;
    localparam int DW = 2 * W;

    logic [DW-1:0] prod;

    always_comb begin
        prod = neg ? (~acc + DW'(1)) : acc;
        if (!is_div) begin
            res = wide ? prod : {keep[DW-1:W], prod[W-1:0]};
        end else if (dz) begin
            res = keep;
        end else if (wide) begin
            res = {acc[W-1:0], quo};
        end else begin
            res = {keep[DW-1:W], acc[HW-1:0], quo[HW-1:0]};
        end
    end

endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq
    import muldiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [1:0]     op,
    input  logic           wide,
    input  logic [2*W-1:0] dst_in,
    input  logic [W-1:0]   src_in,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] result,
    output logic           flag_n,
    output logic           flag_z,
    output logic           flag_dz
);
    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic          is_div;
        logic          wide;
        logic          neg;
        logic          dz;
        logic          dmsb;
        logic [DW-1:0] acc;
        logic [DW-1:0] mq;
        logic [DW-1:0] mc;
        logic [DW-1:0] keep;
        logic [DW-1:0] res;
        logic          fn;
        logic          fz;
        logic          fdz;
    } md_state_t;

    md_state_t st_d, st_q;

    md_op_e        op_e;
    logic          accept;
    logic [DW-1:0] acc_init, mq_init, mc_init;
    logic [CW-1:0] cnt_init;
    logic          ld_div, ld_neg, ld_dz, ld_dmsb;
    logic [DW-1:0] acc_n, mq_n, mc_n;
    logic [DW-1:0] res_pk;

    assign op_e   = md_op_e'(op);
    assign accept = start && !st_q.busy && (op_e != OP_RSVD);

    muldiv_prep #(.W(W)) u_prep (
        .op       (op_e),
        .wide     (wide),
        .dst      (dst_in),
        .src      (src_in),
        .acc_init (acc_init),
        .mq_init  (mq_init),
        .mc_init  (mc_init),
        .cnt_init (cnt_init),
        .is_div   (ld_div),
        .neg      (ld_neg),
        .dz       (ld_dz),
        .dmsb     (ld_dmsb)
    );

    muldiv_step #(.W(W)) u_step (
        .is_div (st_q.is_div),
        .acc    (st_q.acc),
        .mq     (st_q.mq),
        .mc     (st_q.mc),
        .acc_n  (acc_n),
        .mq_n   (mq_n),
        .mc_n   (mc_n)
    );

    muldiv_pack #(.W(W)) u_pack (
        .is_div (st_q.is_div),
        .wide   (st_q.wide),
        .neg    (st_q.neg),
        .dz     (st_q.dz),
        .acc    (acc_n),
        .quo    (mq_n[W-1:0]),
        .keep   (st_q.keep),
        .res    (res_pk)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.acc = acc_n;
            st_d.mq  = mq_n;
            st_d.mc  = mc_n;
            if (st_q.cnt == '0) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.res  = res_pk;
                if (st_q.is_div) begin
                    st_d.fn  = st_q.dmsb;
                    st_d.fz  = st_q.dz;
                    st_d.fdz = st_q.dz;
                end
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end else if (accept) begin
            st_d.busy   = 1'b1;
            st_d.cnt    = cnt_init;
            st_d.is_div = ld_div;
            st_d.wide   = wide;
            st_d.neg    = ld_neg;
            st_d.dz     = ld_dz;
            st_d.dmsb   = ld_dmsb;
            st_d.acc    = acc_init;
            st_d.mq     = mq_init;
            st_d.mc     = mc_init;
            st_d.keep   = dst_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign result  = st_q.res;
    assign flag_n  = st_q.fn;
    assign flag_z  = st_q.fz;
    assign flag_dz = st_q.fdz;

endmodule

// File: rtl/muldiv_chk.sv
module muldiv_chk #(
    parameter int W = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [1:0]     op,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] result,
    input logic           flag_n,
    input logic           flag_z,
    input logic           flag_dz
);
    localparam int HW = W / 2;
    localparam int DW = 2 * W;
    localparam int LW = $clog2(DW) + 2;

    logic [LW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + LW'(1);
        end else begin
            run_len <= '0;
        end
    end

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len == LW'(2) || run_len == LW'(HW) ||
                  run_len == LW'(W) || run_len == LW'(DW)));

    // R6
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op != 2'd3) |=> busy);

    // R10
    rsvd_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && op == 2'd3) |=> !busy);

    // R11
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({flag_n, flag_z, flag_dz}) |-> done);

endmodule

bind muldiv_seq muldiv_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .busy    (busy),
    .done    (done),
    .result  (result),
    .flag_n  (flag_n),
    .flag_z  (flag_z),
    .flag_dz (flag_dz)
);

// File: tb/sim_muldiv_seq.sv
module sim_muldiv_seq;
    localparam int W = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [1:0]  op;
    logic        wide;
    logic [31:0] dst_in;
    logic [15:0] src_in;
    logic        busy;
    logic        done;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_dz;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    string rtag = "R1";
    string ftag = "R1";
    string btag = "R6";

    bit          m_busy, m_done, m_n, m_z, m_dz;
    logic [31:0] m_res;
    int          m_left;
    logic [31:0] p_res;
    bit          p_div, p_n, p_z;

    always #4 clk = ~clk;

    muldiv_seq #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .dst_in(dst_in), .src_in(src_in), .busy(busy), .done(done),
        .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_dz(flag_dz)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
        end
    endtask

    function automatic void ref_eval(input logic [1:0] o, input logic w,
                                     input logic [31:0] d, input logic [15:0] s,
                                     output logic [31:0] r, output int lat,
                                     output bit dv, output bit n, output bit z);
        longint a, b, p;
        longint unsigned ua, ub, qq, rr;
        dv = (o == 2'd2);
        n  = 1'b0;
        z  = 1'b0;
        if (o == 2'd0) begin
            ua = w ? longint'(d[15:0]) : longint'(d[7:0]);
            ub = w ? longint'(s) : longint'(s[7:0]);
            p  = longint'(ua * ub);
        end else begin
            a = w ? longint'($signed(d[15:0])) : longint'($signed(d[7:0]));
            b = w ? longint'($signed(s)) : longint'($signed(s[7:0]));
            p = a * b;
        end
        if (!dv) begin
            r   = w ? p[31:0] : {d[31:16], p[15:0]};
            lat = w ? 16 : 8;
        end else begin
            ua = w ? longint'(d) : longint'(d[15:0]);
            ub = w ? longint'(s) : longint'(s[7:0]);
            n  = w ? s[15] : s[7];
            if (ub == 0) begin
                z   = 1'b1;
                r   = d;
                lat = 2;
            end else begin
                qq  = ua / ub;
                rr  = ua % ub;
                r   = w ? {rr[15:0], qq[15:0]} : {d[31:16], rr[7:0], qq[7:0]};
                lat = w ? 32 : 16;
            end
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_res = '0;
            m_n = 0; m_z = 0; m_dz = 0; m_left = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    m_res  = p_res;
                    if (p_div) begin
                        m_n = p_n; m_z = p_z; m_dz = p_z;
                    end
                end
            end else if (start && op != 2'd3) begin
                ref_eval(op, wide, dst_in, src_in, p_res, m_left, p_div, p_n, p_z);
                m_busy = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(busy === m_busy, btag, "busy", {31'b0, busy}, {31'b0, m_busy});
            check(done === m_done, btag, "done", {31'b0, done}, {31'b0, m_done});
            check(result === m_res, rtag, "result", result, m_res);
            check({flag_n, flag_z, flag_dz} === {m_n, m_z, m_dz}, ftag, "flags",
                  {29'b0, flag_n, flag_z, flag_dz}, {29'b0, m_n, m_z, m_dz});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL R6 watchdog act=%0d exp=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_op(input logic [1:0] o, input logic w,
                         input logic [31:0] d, input logic [15:0] s, input bit inj);
        bit dzero;
        dzero = (o == 2'd2) && ((w ? s : {8'h00, s[7:0]}) == 16'h0);
        if (o == 2'd0)      rtag = "R2";
        else if (o == 2'd1) rtag = "R3";
        else if (dzero)     rtag = "R7";
        else                rtag = w ? "R5" : "R4";
        ftag = (o != 2'd2) ? "R9" : (dzero ? "R7" : "R8");
        btag = (inj && !dzero) ? "R10" : "R6";
        start = 1'b1; op = o; wide = w; dst_in = d; src_in = s;
        @(negedge clk);
        start = 1'b0; dst_in = $urandom; src_in = 16'($urandom); wide = ~w;
        if (inj && !dzero) begin
            @(negedge clk);
            start = 1'b1; op = 2'($urandom_range(0, 2));
            @(negedge clk);
            start = 1'b0;
        end
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
        btag = "R6";
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; op = 2'd0; wide = 1'b0;
        dst_in = '0; src_in = '0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R1", "busy in reset", {31'b0, busy}, 32'h0);
        check(done === 1'b0, "R1", "done in reset", {31'b0, done}, 32'h0);
        check(result === 32'h0, "R1", "result in reset", result, 32'h0);
        check({flag_n, flag_z, flag_dz} === 3'b000, "R1", "flags in reset",
              {29'b0, flag_n, flag_z, flag_dz}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && result === 32'h0, "R1", "after release",
              result, 32'h0);

        do_op(2'd0, 1'b0, 32'hABCD_00FF, 16'h00FF, 1'b0);
        do_op(2'd0, 1'b1, 32'h0000_FFFF, 16'hFFFF, 1'b1);
        do_op(2'd1, 1'b0, 32'h1111_0080, 16'h0080, 1'b0);
        do_op(2'd1, 1'b0, 32'h2222_00FF, 16'h0001, 1'b1);
        do_op(2'd1, 1'b0, 32'h0000_007F, 16'h0080, 1'b0);
        do_op(2'd1, 1'b1, 32'h0000_8000, 16'h8000, 1'b0);
        do_op(2'd1, 1'b1, 32'h0000_7FFF, 16'h8001, 1'b0);
        do_op(2'd2, 1'b0, 32'h5555_1234, 16'h0056, 1'b1);
        do_op(2'd2, 1'b0, 32'h0000_FFFF, 16'h0001, 1'b0);
        do_op(2'd2, 1'b0, 32'h0000_0F00, 16'h0080, 1'b0);
        do_op(2'd2, 1'b1, 32'h1234_5678, 16'h1234, 1'b1);
        do_op(2'd2, 1'b1, 32'hFFFF_FFFF, 16'h8001, 1'b0);
        do_op(2'd2, 1'b0, 32'h9876_5432, 16'hFF00, 1'b0);
        do_op(2'd2, 1'b1, 32'hCAFE_BABE, 16'h0000, 1'b0);
        do_op(2'd0, 1'b0, 32'h0000_0003, 16'h0005, 1'b0);

        rtag = "R10"; ftag = "R10"; btag = "R10";
        start = 1'b1; op = 2'd3; wide = 1'b1; dst_in = 32'h1234_5678; src_in = 16'h0003;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R10", "reserved op busy", {31'b0, busy}, 32'h0);

        rtag = "R11"; ftag = "R11"; btag = "R11";
        repeat (8) begin
            dst_in = $urandom; src_in = 16'($urandom); wide = ~wide;
            @(negedge clk);
        end

        for (int i = 0; i < 300; i++) begin
            logic [15:0] sv;
            sv = ($urandom_range(0, 7) == 0) ? 16'h0 : 16'($urandom);
            do_op(2'($urandom_range(0, 2)), 1'($urandom_range(0, 1)),
                  $urandom, sv, 1'($urandom_range(0, 1)));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule